// File: doc/BRIEF.md
# Per-CPU Highest-Priority Pending Interrupt Selector

This block decides, for each processor in a cluster, which interrupt should be presented next. It looks at two groups of candidates. The first is the processor's own view of the sixteen inter-processor (software-generated) interrupts. The second is the set of peripheral interrupt lines that are both enabled and pending. For each processor it picks the candidate with the most urgent priority and registers that identifier. It also drives an interrupt request line to that processor when the request is allowed.

The peripheral pending state is held inside the block. It is changed by one-cycle set and clear pulse vectors, and the identifiers reserved for inter-processor interrupts are protected from those pulses. Line priorities, enables, active flags, the per-processor inter-processor pending views, the global enable, the per-processor interface enables and the per-processor priority masks all come from the surrounding register file. An acknowledge pulse from a processor clears its presented selection until the next evaluation.

Top module: `hpps_top`

## Requirements
- R1: Priority values are 8 bits, and a smaller value is more urgent. A candidate wins only when its priority is strictly less than both the processor's mask and every candidate seen before it. A priority equal to the mask never wins.
- R2: When no candidate qualifies for an enabled processor, its selected id becomes 1023 and its request line is low.
- R3: The sixteen inter-processor ids (0 to 15, taken from that processor's 16-bit pending view, bit s = id s) are examined before the peripheral lines. Peripheral lines are examined in ascending id order. On equal priority the candidate examined first is kept.
- R4: A peripheral line is a candidate only when its enable bit and its pending bit are both set.
- R5: The request line is high only when the global enable is set, the processor interface is enabled, a winner exists, and the active bit of the winning id is clear. The selected id is updated even when the request is withheld.
- R6: While a processor interface is disabled, its selected id and request line keep their previous values.
- R7: After reset every selected id reads 1023, every request line is low, and all pending bits are clear.
- R8: Set and clear pulses never change pending bits 0 to 15. For the other bits, when set and clear hit the same bit in the same cycle, set wins.
- R9: A change on any level input shows on the outputs after exactly one rising clock edge. A pending pulse shows after two edges.
- R10: An acknowledge pulse makes that processor's selected id 1023 and its request low on the next edge, whatever its enable. Evaluation resumes on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dist_en | input | 1 | Global interrupt forwarding enable |
| cpu_en | input | NUM_CPU | Per-processor interface enable |
| prio_mask | input | NUM_CPU*PRIO_W | Per-processor priority threshold, processor c at bits c*PRIO_W upward |
| line_prio | input | NUM_LINES*PRIO_W | Priority of each id, id n at bits n*PRIO_W upward |
| line_en | input | NUM_LINES | Peripheral line enable bits |
| line_act | input | NUM_LINES | Active flags, one per id |
| pend_set | input | NUM_LINES | One-cycle pending set pulses |
| pend_clr | input | NUM_LINES | One-cycle pending clear pulses |
| sgi_pend | input | NUM_CPU*NUM_SGI | Per-processor inter-processor pending views, processor c at bits c*NUM_SGI upward |
| ack | input | NUM_CPU | Per-processor acknowledge pulse |
| sel_id | output | NUM_CPU*10 | Registered selected id per processor, 1023 when none |
| irq | output | NUM_CPU | Registered interrupt request per processor |

## Verification
The hardest situation to reach from the ports is a close contest. An inter-processor id and one or more peripheral lines carry the same priority, and that priority sits just under the mask, so both the tie rule and the strict comparison decide the result. Directed cases build these contests on purpose. The random phase then draws priorities from only sixteen values and masks from a narrow band, so ties and near-threshold winners come up in many iterations. Interface enables are toggled in the same cycle as pending pulses, which exercises the hold behaviour while the pending state is still moving.

// File: rtl/hpps_pkg.sv
package hpps_pkg;
   localparam int ID_W = 10;
   localparam logic [ID_W-1:0] NO_IRQ_ID = 10'd1023;
endpackage

// File: rtl/hpps_pend_reg.sv
module hpps_pend_reg #(
   parameter int NUM_LINES = 64,
   parameter int NUM_SGI   = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] set_i,
   input  logic [NUM_LINES-1:0] clr_i,
   output logic [NUM_LINES-1:0] pend_o
);
   localparam logic [NUM_LINES-1:0] WRITABLE = {{(NUM_LINES-NUM_SGI){1'b1}}, {NUM_SGI{1'b0}}};

   logic [NUM_LINES-1:0] pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= ((pend_q & ~clr_i) | set_i) & WRITABLE;
   end

   assign pend_o = pend_q;

   // R8
   sgi_bits_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i[NUM_SGI-1:0]) |=> (pend_o[NUM_SGI-1:0] == '0));

   // R8
   set_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i[NUM_LINES-1] && clr_i[NUM_LINES-1]) |=> pend_o[NUM_LINES-1]);
endmodule

// File: rtl/hpps_scan.sv
module hpps_scan
   import hpps_pkg::*;
#(
   parameter int NUM_LINES = 64,
   parameter int NUM_SGI   = 16,
   parameter int PRIO_W    = 8
) (
   input  logic [NUM_LINES*PRIO_W-1:0] prio_i,
   input  logic [NUM_LINES-1:0]        en_i,
   input  logic [NUM_LINES-1:0]        pend_i,
   input  logic [NUM_LINES-1:0]        act_i,
   input  logic [NUM_SGI-1:0]          sgi_i,
   input  logic [PRIO_W-1:0]           mask_i,
   output logic                        found_o,
   output logic [ID_W-1:0]             win_id_o,
   output logic [PRIO_W-1:0]           win_prio_o,
   output logic                        win_act_o
);
   always_comb begin
      logic [PRIO_W-1:0] best;
      best       = mask_i;
      found_o    = 1'b0;
      win_id_o   = NO_IRQ_ID;
      win_act_o  = 1'b0;
      // inter-processor ids first
      for (int s = 0; s < NUM_SGI; s++) begin
         if (sgi_i[s] && (prio_i[s*PRIO_W +: PRIO_W] < best)) begin
            best      = prio_i[s*PRIO_W +: PRIO_W];
            found_o   = 1'b1;
            win_id_o  = ID_W'(s);
            win_act_o = act_i[s];
         end
      end
      // peripheral lines in ascending order
      for (int l = 0; l < NUM_LINES; l++) begin
         if (en_i[l] && pend_i[l] && (prio_i[l*PRIO_W +: PRIO_W] < best)) begin
            best      = prio_i[l*PRIO_W +: PRIO_W];
            found_o   = 1'b1;
            win_id_o  = ID_W'(l);
            win_act_o = act_i[l];
         end
      end
      win_prio_o = best;
   end
endmodule

// File: rtl/hpps_cpu_out.sv
module hpps_cpu_out
   import hpps_pkg::*;
#(
   parameter int PRIO_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dist_en,
   input  logic              cpu_en,
   input  logic              ack,
   input  logic              found,
   input  logic [ID_W-1:0]   win_id,
   input  logic [PRIO_W-1:0] win_prio,
   input  logic [PRIO_W-1:0] mask,
   input  logic              win_act,
   output logic [ID_W-1:0]   sel_id,
   output logic              irq
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_id <= NO_IRQ_ID;
         irq    <= 1'b0;
      end else if (ack) begin
         sel_id <= NO_IRQ_ID;
         irq    <= 1'b0;
      end else if (cpu_en) begin
         sel_id <= found ? win_id : NO_IRQ_ID;
         irq    <= found && dist_en && !win_act;
      end
   end

   // R1
   winner_below_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> (win_prio < mask));

   // R2
   irq_has_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (sel_id != NO_IRQ_ID));

   // R5
   dist_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dist_en && cpu_en) |=> !irq);

   // R6
   hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_en && !ack) |=> ($stable(sel_id) && $stable(irq)));

   // R10
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> (sel_id == NO_IRQ_ID && !irq));
endmodule

// File: rtl/hpps_top.sv
module hpps_top
   import hpps_pkg::*;
#(
   parameter int NUM_CPU   = 4,
   parameter int NUM_LINES = 64,
   parameter int NUM_SGI   = 16,
   parameter int PRIO_W    = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        dist_en,
   input  logic [NUM_CPU-1:0]          cpu_en,
   input  logic [NUM_CPU*PRIO_W-1:0]   prio_mask,
   input  logic [NUM_LINES*PRIO_W-1:0] line_prio,
   input  logic [NUM_LINES-1:0]        line_en,
   input  logic [NUM_LINES-1:0]        line_act,
   input  logic [NUM_LINES-1:0]        pend_set,
   input  logic [NUM_LINES-1:0]        pend_clr,
   input  logic [NUM_CPU*NUM_SGI-1:0]  sgi_pend,
   input  logic [NUM_CPU-1:0]          ack,
   output logic [NUM_CPU*ID_W-1:0]     sel_id,
   output logic [NUM_CPU-1:0]          irq
);
   generate
      if (NUM_CPU < 1 || NUM_CPU > 8) begin : g_bad_cpu
         $error("hpps_top: NUM_CPU must be 1..8");
      end
      if (NUM_LINES <= NUM_SGI || NUM_LINES > 1020) begin : g_bad_lines
         $error("hpps_top: NUM_LINES must exceed NUM_SGI and stay below 1021");
      end
      if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio
         $error("hpps_top: PRIO_W must be 1..8");
      end
   endgenerate

   logic [NUM_LINES-1:0] pend_q;

   hpps_pend_reg #(.NUM_LINES(NUM_LINES), .NUM_SGI(NUM_SGI)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (pend_set),
      .clr_i  (pend_clr),
      .pend_o (pend_q)
   );

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      logic              found;
      logic [ID_W-1:0]   win_id;
      logic [PRIO_W-1:0] win_prio;
      logic              win_act;

      hpps_scan #(.NUM_LINES(NUM_LINES), .NUM_SGI(NUM_SGI), .PRIO_W(PRIO_W)) u_scan (
         .prio_i     (line_prio),
         .en_i       (line_en),
         .pend_i     (pend_q),
         .act_i      (line_act),
         .sgi_i      (sgi_pend[c*NUM_SGI +: NUM_SGI]),
         .mask_i     (prio_mask[c*PRIO_W +: PRIO_W]),
         .found_o    (found),
         .win_id_o   (win_id),
         .win_prio_o (win_prio),
         .win_act_o  (win_act)
      );

      hpps_cpu_out #(.PRIO_W(PRIO_W)) u_out (
         .clk      (clk),
         .rst_n    (rst_n),
         .dist_en  (dist_en),
         .cpu_en   (cpu_en[c]),
         .ack      (ack[c]),
         .found    (found),
         .win_id   (win_id),
         .win_prio (win_prio),
         .mask     (prio_mask[c*PRIO_W +: PRIO_W]),
         .win_act  (win_act),
         .sel_id   (sel_id[c*ID_W +: ID_W]),
         .irq      (irq[c])
      );
   end
endmodule

// File: tb/hpps_top_tb.sv
`timescale 1ns/1ps
module hpps_top_tb;
   localparam int NC = 4, NL = 64, NS = 16, PW = 8, IW = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dist_en = 1'b0;
   logic [NC-1:0] cpu_en = '0;
   logic [NC*PW-1:0] prio_mask = '1;
   logic [NL*PW-1:0] line_prio = '0;
   logic [NL-1:0] line_en = '0, line_act = '0, pend_set = '0, pend_clr = '0;
   logic [NC*NS-1:0] sgi_pend = '0;
   logic [NC-1:0] ack = '0;
   logic [NC*IW-1:0] sel_id;
   logic [NC-1:0] irq;

   int checks = 0, errors = 0, cycles = 0;
   bit done = 0;
   logic [NL-1:0] pend_m = '0;
   int exp_id [NC];
   bit exp_irq [NC];

   hpps_top u_dut (.clk(clk), .rst_n(rst_n), .dist_en(dist_en), .cpu_en(cpu_en),
      .prio_mask(prio_mask), .line_prio(line_prio), .line_en(line_en), .line_act(line_act),
      .pend_set(pend_set), .pend_clr(pend_clr), .sgi_pend(sgi_pend), .ack(ack),
      .sel_id(sel_id), .irq(irq));

   always #4 clk = ~clk;

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   function automatic void ref_eval(input int c, output int id, output bit irqv);
      int best = int'(prio_mask[c*PW +: PW]);
      bit found = 0;
      id = 1023;
      for (int s = 0; s < NS; s++)
         if (sgi_pend[c*NS+s] && int'(line_prio[s*PW +: PW]) < best) begin
            best = int'(line_prio[s*PW +: PW]); id = s; found = 1;
         end
      for (int l = 0; l < NL; l++)
         if (line_en[l] && pend_m[l] && int'(line_prio[l*PW +: PW]) < best) begin
            best = int'(line_prio[l*PW +: PW]); id = l; found = 1;
         end
      irqv = found && dist_en && !line_act[id % NL];
   endfunction

   task automatic update_exp();
      for (int c = 0; c < NC; c++)
         if (cpu_en[c]) ref_eval(c, exp_id[c], exp_irq[c]);
   endtask

   task automatic check_all(input string req);
      for (int c = 0; c < NC; c++) begin
         checks++;
         if (int'(sel_id[c*IW +: IW]) != exp_id[c]) begin
            errors++;
            $display("FAIL %s cpu%0d id: actual %0d expected %0d", req, c, sel_id[c*IW +: IW], exp_id[c]);
         end
         checks++;
         if (irq[c] != exp_irq[c]) begin
            errors++;
            $display("FAIL %s cpu%0d irq: actual %0d expected %0d", req, c, irq[c], exp_irq[c]);
         end
      end
   endtask

   // caller changes inputs just after a falling edge, then calls this
   task automatic settle(input string req);
      pend_m = ((pend_m & ~pend_clr) | pend_set);
      pend_m[NS-1:0] = '0;
      @(negedge clk);
      pend_set = '0; pend_clr = '0;
      @(negedge clk); @(negedge clk);
      update_exp();
      check_all(req);
   endtask

   task automatic set_prio(input int n, input int p);
      line_prio[n*PW +: PW] = PW'(p);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      for (int c = 0; c < NC; c++) begin exp_id[c] = 1023; exp_irq[c] = 0; end
      repeat (3) @(negedge clk);
      check_all("R7 reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R7 after release");

      // R4: enabled but not pending, then pending
      cpu_en = 4'b0001; dist_en = 1; set_prio(20, 5); line_en[20] = 1;
      settle("R4 not pending");
      pend_set[20] = 1;
      settle("R4 enabled+pending");
      line_en[20] = 0;
      settle("R4 disabled line");
      line_en[20] = 1;
      settle("R4 re-enabled");

      // R8: low ids ignored, set beats clear
      line_en[3] = 1; set_prio(3, 0); pend_set[3] = 1;
      settle("R8 low id ignored");
      line_en[30] = 1; set_prio(30, 1); pend_set[30] = 1; pend_clr[30] = 1;
      settle("R8 set wins");
      pend_clr[30] = 1;
      settle("R8 clear");

      // R3: SGI tie and ascending order tie
      cpu_en = 4'b0011; sgi_pend[0*NS+5] = 1; set_prio(5, 5);
      settle("R3 sgi tie");
      set_prio(40, 2); set_prio(33, 2); line_en[40] = 1; line_en[33] = 1;
      pend_set[40] = 1; pend_set[33] = 1;
      settle("R3 ascending tie");
      sgi_pend[1*NS+9] = 1; set_prio(9, 2);
      settle("R3 sgi before line");

      // R1: mask equal to best never wins
      prio_mask[0 +: PW] = 8'd2;
      settle("R1 equal to mask");
      prio_mask[0 +: PW] = 8'd3;
      settle("R1 below mask");

      // R5: active winner and global disable
      line_act[33] = 1;
      settle("R5 active winner");
      line_act[33] = 0; dist_en = 0;
      settle("R5 dist off");
      dist_en = 1;
      settle("R5 dist on");

      // R6: disabled interface holds
      cpu_en = 4'b0010; set_prio(33, 0);
      settle("R6 hold");
      cpu_en = 4'b0011;
      settle("R6 resume");

      // R9: one edge after a level change
      prio_mask[PW +: PW] = 8'd0;
      @(negedge clk);
      exp_id[1] = 1023; exp_irq[1] = 0;
      check_all("R9 one cycle");
      prio_mask[PW +: PW] = 8'hFF;
      settle("R9 restore");

      // R10: acknowledge clears, then evaluation resumes
      ack = 4'b0011;
      @(negedge clk);
      ack = '0;
      exp_id[0] = 1023; exp_irq[0] = 0; exp_id[1] = 1023; exp_irq[1] = 0;
      check_all("R10 ack");
      @(negedge clk);
      update_exp();
      check_all("R10 resume");

      // random phase
      for (int it = 0; it < 80; it++) begin
         for (int n = 0; n < NL; n++) if ($urandom % 8 == 0) set_prio(n, $urandom % 16);
         line_en  = {$urandom, $urandom};
         line_act = {$urandom, $urandom} & {$urandom, $urandom};
         pend_set = {$urandom, $urandom} & {$urandom, $urandom};
         pend_clr = {$urandom, $urandom} & {$urandom, $urandom};
         sgi_pend = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
         for (int c = 0; c < NC; c++)
            prio_mask[c*PW +: PW] = ($urandom % 4 == 0) ? 8'hFF : PW'(2 + $urandom % 14);
         cpu_en  = NC'($urandom);
         dist_en = ($urandom % 5 != 0);
         settle("R1 R3 R4 R5 R6 R8 random");
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule